// File: doc/BRIEF.md
# SPI Receive Frame Queue with Overflow Policy

This block buffers frames that a serial shift register has finished receiving, so that software can collect them later. Each completed frame is written into a four-entry queue. A read of the pop register takes the oldest entry out of the queue and presents it on the read-data output. The block also publishes two values: how many entries the queue holds, and the index of the entry that the next pop will return. The index counts up by one on each pop and wraps after the last entry.

The queue may be full when a frame completes. In that case the frame stays in the shift register, which acts as one extra holding stage. When a slot frees up, the held frame moves into the queue on the next cycle. A frame that arrives while both the queue and the holding stage are occupied is an overflow. It sets a sticky flag, and a control input decides what happens to the frame. When the control is high, the new frame replaces the held one. When it is low, the new frame is discarded. A flush empties the queue and the holding stage at once.

Top module: `spi_rxq`

## Requirements
- R1: After reset, the occupancy is 0, the pop index is 0, the overflow flag is 0 and the read data is 0.
- R2: A completed frame (`frm_done` high) that arrives while the queue holds fewer than 4 entries and no frame is held is stored, and the occupancy rises by one in the next cycle.
- R3: A pop (`pop_rd` high) on a non-empty queue puts the oldest stored frame on `pop_data` in the next cycle. The occupancy falls by one and the pop index advances by one modulo 4.
- R4: A pop on an empty queue leaves `pop_data`, the pop index and the occupancy unchanged.
- R5: A frame that completes while the queue is full and no frame is held is kept in the holding stage. The occupancy stays 4 and no overflow is flagged.
- R6: When the occupancy drops below 4 while a frame is held, the held frame enters the queue in the following cycle. It is popped after the frames that were already queued.
- R7: A frame that completes while the queue is full and a frame is held sets the overflow flag. The flag stays set until a flush or a reset.
- R8: On overflow with `ovwr_en` high, the new frame replaces the held frame. With `ovwr_en` low, the new frame is discarded and the held frame is kept.
- R9: A frame and a pop in the same cycle on a queue holding 1 to 3 entries leave the occupancy unchanged, and the pop index advances.
- R10: A flush sets the occupancy and the pop index to 0, discards any held frame and clears the overflow flag. It takes priority over a pop or a frame in the same cycle, and it leaves `pop_data` unchanged.
- R11: The occupancy never exceeds 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frm_done | input | 1 | A frame has completed in the shift register this cycle |
| frm_data | input | 16 | Completed frame contents |
| pop_rd | input | 1 | Pop-register read strobe |
| flush | input | 1 | Empty the queue and the holding stage |
| ovwr_en | input | 1 | On overflow, 1 replaces the held frame and 0 discards the new frame |
| pop_data | output | 16 | Frame returned by the most recent successful pop |
| occ | output | 3 | Number of valid queue entries |
| pop_ptr | output | 2 | Index of the entry the next pop returns |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The hardest situation to reach is an overflow, in which the held frame is then either kept or replaced. It needs a full queue, a frame already waiting in the holding stage, and yet another frame, all with no pop in between. The effect of the overflow policy shows only after four further pops drain the queue down to the held frame. Directed sequences fill the queue past capacity under both policy settings and then drain it. Random phases that weight frames above pops return to that edge repeatedly and mix in same-cycle pops and flushes.

// File: rtl/spi_rxq_pkg.sv
package spi_rxq_pkg;
   typedef enum logic [1:0] {
      ROUTE_NONE = 2'd0,
      ROUTE_BUF  = 2'd1,
      ROUTE_HOLD = 2'd2,
      ROUTE_DROP = 2'd3
   } rx_route_e;

   function automatic bit depth_ok(input int depth);
      return (depth >= 2) && ((depth & (depth - 1)) == 0);
   endfunction
endpackage

// File: rtl/spi_rxq_hold.sv
module spi_rxq_hold #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          clr,
   input  logic [DW-1:0] din,
   output logic          hv,
   output logic [DW-1:0] hd
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hv <= 1'b0;
         hd <= '0;
      end else if (clr) begin
         hv <= 1'b0;
      end else if (load) begin
         hv <= 1'b1;
         hd <= din;
      end
   end
endmodule

// File: rtl/spi_rxq_store.sv
module spi_rxq_store #(
   parameter int DW    = 16,
   parameter int DEPTH = 4,
   localparam int PW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [PW-1:0] wptr,
   input  logic [DW-1:0] wdata,
   input  logic          rd_en,
   input  logic [PW-1:0] rptr,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] slot [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot[i] <= '0;
         else if (wr_en && (wptr == PW'(i)))
            slot[i] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata <= '0;
      else if (rd_en)
         rdata <= slot[rptr];
   end
endmodule

// File: rtl/spi_rxq_ctrl.sv
module spi_rxq_ctrl
   import spi_rxq_pkg::*;
#(
   parameter int DEPTH = 4,
   localparam int PW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          frm_done,
   input  logic          pop_rd,
   input  logic          flush,
   input  logic          ovwr_en,
   input  logic          hv,
   output logic          wr_en,
   output logic          wr_from_hold,
   output logic          rd_en,
   output logic          hold_load,
   output logic          hold_clr,
   output logic [PW-1:0] wptr,
   output logic [PW-1:0] rptr,
   output logic [CW-1:0] occ,
   output logic          ovf
);
   logic      room;
   logic      drain;
   rx_route_e route;

   assign room  = (occ != CW'(DEPTH));
   assign drain = !flush && hv && room;
   assign rd_en = !flush && pop_rd && (occ != '0);

   always_comb begin
      route = ROUTE_NONE;
      if (!flush && frm_done) begin
         if (!hv && room)
            route = ROUTE_BUF;
         else if (drain || !hv)
            route = ROUTE_HOLD;
         else
            route = ROUTE_DROP;
      end
   end

   assign wr_from_hold = drain;
   assign wr_en        = drain || (route == ROUTE_BUF);
   assign hold_load    = (route == ROUTE_HOLD) || ((route == ROUTE_DROP) && ovwr_en);
   assign hold_clr     = flush || (drain && (route != ROUTE_HOLD));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         occ  <= '0;
         ovf  <= 1'b0;
      end else if (flush) begin
         wptr <= '0;
         rptr <= '0;
         occ  <= '0;
         ovf  <= 1'b0;
      end else begin
         if (wr_en)
            wptr <= wptr + 1'b1;
         if (rd_en)
            rptr <= rptr + 1'b1;
         if (wr_en && !rd_en)
            occ <= occ + 1'b1;
         else if (rd_en && !wr_en)
            occ <= occ - 1'b1;
         if (route == ROUTE_DROP)
            ovf <= 1'b1;
      end
   end
endmodule

// File: rtl/spi_rxq.sv
module spi_rxq
   import spi_rxq_pkg::*;
#(
   parameter int DW    = 16,
   parameter int DEPTH = 4,
   localparam int PW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          frm_done,
   input  logic [DW-1:0] frm_data,
   input  logic          pop_rd,
   input  logic          flush,
   input  logic          ovwr_en,
   output logic [DW-1:0] pop_data,
   output logic [CW-1:0] occ,
   output logic [PW-1:0] pop_ptr,
   output logic          ovf
);
   if (!depth_ok(DEPTH)) begin : g_bad_depth
      $error("spi_rxq: DEPTH must be a power of two, at least 2");
   end
   if (DW < 1) begin : g_bad_width
      $error("spi_rxq: DW must be positive");
   end

   logic          wr_en, wr_from_hold, rd_en, hold_load, hold_clr, hv;
   logic [PW-1:0] wptr, rptr;
   logic [DW-1:0] hd, wdata;

   spi_rxq_ctrl #(.DEPTH(DEPTH)) ctrl_i (
      .clk(clk), .rst_n(rst_n), .frm_done(frm_done), .pop_rd(pop_rd),
      .flush(flush), .ovwr_en(ovwr_en), .hv(hv), .wr_en(wr_en),
      .wr_from_hold(wr_from_hold), .rd_en(rd_en), .hold_load(hold_load),
      .hold_clr(hold_clr), .wptr(wptr), .rptr(rptr), .occ(occ), .ovf(ovf)
   );

   spi_rxq_hold #(.DW(DW)) hold_i (
      .clk(clk), .rst_n(rst_n), .load(hold_load), .clr(hold_clr),
      .din(frm_data), .hv(hv), .hd(hd)
   );

   assign wdata = wr_from_hold ? hd : frm_data;

   spi_rxq_store #(.DW(DW), .DEPTH(DEPTH)) store_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wptr(wptr), .wdata(wdata),
      .rd_en(rd_en), .rptr(rptr), .rdata(pop_data)
   );

   assign pop_ptr = rptr;
endmodule

// File: rtl/spi_rxq_chk.sv
module spi_rxq_chk #(
   parameter int DW    = 16,
   parameter int DEPTH = 4,
   localparam int PW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          frm_done,
   input logic [DW-1:0] frm_data,
   input logic          pop_rd,
   input logic          flush,
   input logic          ovwr_en,
   input logic [DW-1:0] pop_data,
   input logic [CW-1:0] occ,
   input logic [PW-1:0] pop_ptr,
   input logic          ovf
);
   // R11
   occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= CW'(DEPTH));

   // R2
   occ_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_done && !pop_rd && !flush && occ < CW'(DEPTH)) |=> occ == $past(occ) + 1'b1);

   // R3
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_rd && !flush && occ != '0) |=> pop_ptr == $past(pop_ptr) + 1'b1);

   // R4
   empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_rd && !flush && !frm_done && occ == '0) |=>
         ($stable(pop_data) && $stable(pop_ptr) && occ == '0));

   // R7
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !flush) |=> ovf);

   // R9
   same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_done && pop_rd && !flush && occ != '0 && occ != CW'(DEPTH)) |=>
         occ == $past(occ));

   // R10
   flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (occ == '0 && pop_ptr == '0 && !ovf && $stable(pop_data)));
endmodule

bind spi_rxq spi_rxq_chk #(.DW(DW), .DEPTH(DEPTH)) chk_i (
   .clk(clk), .rst_n(rst_n), .frm_done(frm_done), .frm_data(frm_data),
   .pop_rd(pop_rd), .flush(flush), .ovwr_en(ovwr_en), .pop_data(pop_data),
   .occ(occ), .pop_ptr(pop_ptr), .ovf(ovf)
);

// File: tb/spi_rxq_tb_top.sv
module spi_rxq_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frm_done = 1'b0, pop_rd = 1'b0, flush = 1'b0, ovwr_en = 1'b0;
   logic [15:0] frm_data = '0;
   logic [15:0] pop_data;
   logic [2:0]  occ;
   logic [1:0]  pop_ptr;
   logic        ovf;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // reference state
   int unsigned q[$];
   bit          m_hv = 0;
   int unsigned m_hd = 0;
   bit          m_ovf = 0;
   int unsigned m_last = 0;
   int unsigned m_ptr = 0;

   always #5 clk = ~clk;

   spi_rxq dut_i (
      .clk(clk), .rst_n(rst_n), .frm_done(frm_done), .frm_data(frm_data),
      .pop_rd(pop_rd), .flush(flush), .ovwr_en(ovwr_en), .pop_data(pop_data),
      .occ(occ), .pop_ptr(pop_ptr), .ovf(ovf)
   );

   task automatic chk(string tag, string what, int unsigned act, int unsigned exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic model_step(bit f, int unsigned d, bit p, bit fl, bit ow);
      int n0;
      if (fl) begin
         q.delete(); m_hv = 0; m_ovf = 0; m_ptr = 0;
         return;
      end
      n0 = q.size();
      if (p && n0 > 0) begin
         m_last = q.pop_front();
         m_ptr = (m_ptr + 1) % 4;
      end
      if (m_hv && n0 < 4) begin
         q.push_back(m_hd);
         m_hv = 0;
         if (f) begin m_hv = 1; m_hd = d; end
      end else if (f) begin
         if (!m_hv && n0 < 4) q.push_back(d);
         else if (!m_hv) begin m_hv = 1; m_hd = d; end
         else begin m_ovf = 1; if (ow) m_hd = d; end
      end
   endtask

   task automatic compare(string tag);
      chk(tag, "occ", occ, q.size());
      chk(tag, "pop_ptr", pop_ptr, m_ptr);
      chk(tag, "ovf", ovf, m_ovf);
      chk(tag, "pop_data", pop_data, m_last);
      chk("R11", "occ_bound", (occ <= 3'd4), 1);
   endtask

   // called at a negedge; applies inputs for one cycle, checks at next negedge
   task automatic step(string tag, bit f, int unsigned d, bit p, bit fl, bit ow);
      frm_done = f; frm_data = d[15:0]; pop_rd = p; flush = fl; ovwr_en = ow;
      @(posedge clk);
      model_step(f, d, p, fl, ow);
      @(negedge clk);
      frm_done = 0; pop_rd = 0; flush = 0;
      compare(tag);
   endtask

   initial begin
      void'($urandom(32'd20240517));
      repeat (3) @(negedge clk);
      compare("R1");
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1");

      // fill four, then one held, then overflow with discard
      for (int i = 0; i < 4; i++) step("R2", 1, 16'h100 + i, 0, 0, 0);
      step("R5", 1, 16'h1AA, 0, 0, 0);
      chk("R5", "occ_full", occ, 4);
      chk("R5", "no_ovf", ovf, 0);
      step("R7", 1, 16'h1BB, 0, 0, 0);
      chk("R7", "ovf_set", ovf, 1);
      step("R3", 0, 0, 1, 0, 0);
      chk("R3", "first_out", pop_data, 16'h100);
      chk("R6", "occ_after_pop", occ, 3);
      step("R6", 0, 0, 0, 0, 0);
      chk("R6", "held_enters", occ, 4);
      step("R7", 0, 0, 0, 0, 0);
      chk("R7", "ovf_kept", ovf, 1);
      for (int i = 0; i < 4; i++) step("R3", 0, 0, 1, 0, 0);
      chk("R8", "discard_keeps_held", pop_data, 16'h1AA);
      step("R4", 0, 0, 1, 0, 0);
      chk("R4", "empty_pop_data", pop_data, 16'h1AA);
      chk("R4", "empty_occ", occ, 0);

      // flush, then overflow with replace
      step("R10", 1, 16'h55, 1, 1, 0);
      chk("R10", "flush_ptr", pop_ptr, 0);
      chk("R10", "flush_ovf", ovf, 0);
      for (int i = 0; i < 5; i++) step("R2", 1, 16'h200 + i, 0, 0, 1);
      step("R8", 1, 16'h2EE, 0, 0, 1);
      for (int i = 0; i < 4; i++) step("R3", 0, 0, 1, 0, 1);
      step("R6", 0, 0, 1, 0, 1);
      chk("R8", "replace_held", pop_data, 16'h2EE);

      // same-cycle frame and pop
      step("R2", 1, 16'h301, 0, 0, 0);
      step("R2", 1, 16'h302, 0, 0, 0);
      step("R9", 1, 16'h303, 1, 0, 0);
      chk("R9", "occ_same", occ, 2);

      // flush discards a held frame
      for (int i = 0; i < 4; i++) step("R2", 1, 16'h400 + i, 0, 0, 0);
      step("R10", 0, 0, 0, 1, 0);
      step("R10", 0, 0, 1, 0, 0);
      chk("R10", "held_gone", occ, 0);

      // random phase
      for (int i = 0; i < 4000; i++) begin
         bit f, p, fl, ow;
         f  = ($urandom % 100) < 60;
         p  = ($urandom % 100) < 40;
         fl = ($urandom % 100) < 2;
         ow = $urandom % 2;
         step("R11", f, $urandom % 65536, p, fl, ow);
      end
      done = 1;
   end

   initial begin
      fork
         begin wait (done); end
         begin
            repeat (150000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule